// File: doc/BRIEF.md
# Hall Commutation Decoder with Protection

This block converts three digitised Hall sensor bits into the six gate commands of a three-phase brushless motor bridge using 120-degree commutation. For each valid rotor position one phase has its high-side switch conducting and another phase has its low-side switch conducting, while the third phase floats. A direction input picks between the forward table and its mirror, in which the two active phases of every position trade roles. Speed control arrives as a single PWM gating bit, and it modulates only the selected low-side switch.

Four fault flags override the table in two tiers. A rotor-lock or overcurrent flag turns off every low-side switch and leaves the high side following the table. An undervoltage or overtemperature flag turns off every switch. Illegal Hall codes also turn everything off. A rotation output, modelled as an open-drain pull-down request, gives either one edge per Hall step or a copy of the first Hall sensor, chosen by a mode input.

The Hall and direction inputs pass through a two-stage synchroniser and all outputs are registered. No port of this block carries a data stream: every pin is a plain level-sensitive control or status signal. There is therefore no valid/ready handshake and no back-pressure.

Top module: `hall_commutator`

## Requirements
- R1: Forward (dir_rev=0) with pwm_gate=1 and no fault: hall_in is {H1,H2,H3} (bit 2 = H1). Phase bit 0 = U, bit 1 = V, bit 2 = W. hs_en_n has bit value 0 when that high side conducts, and ls_on has bit value 1 when that low side conducts. The codes map as follows: 100 gives high W and low U. 110 gives high W and low V. 010 gives high U and low V. 011 gives high U and low W. 001 gives high V and low W. 101 gives high V and low U.
- R2: Reverse (dir_rev=1) swaps the two active phases of each R1 entry. For example, 101 gives high U and low V, and 100 gives high U and low W.
- R3: The selected low-side bit is 1 only while pwm_gate is 1. The high-side pattern does not depend on pwm_gate.
- R4: When flt_lock or flt_oc is 1, ls_on is 000 and hs_en_n still follows the table.
- R5: When flt_uv or flt_ot is 1, hs_en_n is 111 and ls_on is 000.
- R6: Hall codes 000 and 111 give hs_en_n=111, ls_on=000 and fg_low=0 (FG released).
- R7: With fg_sel=0, fg_low is 1 (FG driven low) for codes with two bits set (110, 011, 101) and 0 for codes with one bit set (100, 010, 001), in either direction.
- R8: With fg_sel=1, fg_low is the inverse of H1 for every valid code.
- R9: A change on hall_in or dir_rev reaches the outputs on the third rising clock edge. A change on pwm_gate, a fault flag or fg_sel reaches the outputs on the first rising clock edge.
- R10: While rst_n is 0, hs_en_n is 111, ls_on is 000 and fg_low is 0.
- R11: At most one high side and at most one low side are on at any time, and never both switches of the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Hall bits {H1,H2,H3}, asynchronous |
| dir_rev | input | 1 | 0 = forward, 1 = reverse, asynchronous |
| pwm_gate | input | 1 | Low-side modulation gate |
| flt_uv | input | 1 | Undervoltage fault |
| flt_ot | input | 1 | Overtemperature fault |
| flt_lock | input | 1 | Rotor lock fault |
| flt_oc | input | 1 | Overcurrent fault |
| fg_sel | input | 1 | 0 = edge per step, 1 = follow H1 |
| hs_en_n | output | 3 | High-side enables, active low ({W,V,U}) |
| ls_on | output | 3 | Low-side drive bits ({W,V,U}) |
| fg_low | output | 1 | 1 = pull the rotation output low |

## Verification
The assertions check on every cycle that the outputs are one-hot-or-idle and free of shoot-through. They also check that a supply or thermal fault, a lock or overcurrent fault, or a closed PWM gate in one cycle has silenced the corresponding switches in the next. Only the bench scenarios can show the per-code tables in both directions, the two rotation-output encodings, the illegal-code response and the three-edge synchroniser latency, because these depend on input history that is several cycles deep.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam int PHASES = 3;
  typedef logic [PHASES-1:0] hall_t;
  typedef logic [PHASES-1:0] phase_vec_t;

  typedef struct packed {
    phase_vec_t hs_on;   // one-hot, high side conducting
    phase_vec_t ls_sel;  // one-hot, low side selected
    logic       bad;     // illegal hall code
  } step_t;
endpackage

// File: rtl/hcd_sync.sv
module hcd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hcd_step_lut.sv
module hcd_step_lut
  import hcd_pkg::*;
(
  input  hall_t code,
  input  logic  rev,
  output step_t step
);
  phase_vec_t fwd_hs, fwd_ls;
  logic       bad;

  always_comb begin
    fwd_hs = '0;
    fwd_ls = '0;
    bad    = 1'b0;
    case (code)
      3'b100: begin fwd_hs = 3'b100; fwd_ls = 3'b001; end
      3'b110: begin fwd_hs = 3'b100; fwd_ls = 3'b010; end
      3'b010: begin fwd_hs = 3'b001; fwd_ls = 3'b010; end
      3'b011: begin fwd_hs = 3'b001; fwd_ls = 3'b100; end
      3'b001: begin fwd_hs = 3'b010; fwd_ls = 3'b100; end
      3'b101: begin fwd_hs = 3'b010; fwd_ls = 3'b001; end
      default: bad = 1'b1;
    endcase
  end

  // reverse = same pair of phases with roles exchanged
  assign step.hs_on  = rev ? fwd_ls : fwd_hs;
  assign step.ls_sel = rev ? fwd_hs : fwd_ls;
  assign step.bad    = bad;
endmodule

// File: rtl/hcd_fg_enc.sv
module hcd_fg_enc
  import hcd_pkg::*;
(
  input  hall_t code,
  input  logic  follow_h1,
  output logic  pull_low
);
  // two bits set -> low; one bit set -> released; toggles every step
  logic step_level;
  assign step_level = ~^code;
  assign pull_low   = follow_h1 ? ~code[PHASES-1] : step_level;
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_in,
  input  logic       dir_rev,
  input  logic       pwm_gate,
  input  logic       flt_uv,
  input  logic       flt_ot,
  input  logic       flt_lock,
  input  logic       flt_oc,
  input  logic       fg_sel,
  output logic [2:0] hs_en_n,
  output logic [2:0] ls_on,
  output logic       fg_low
);
  localparam int SW = PHASES + 1;

  logic [SW-1:0] sync_q;
  hall_t         hall_s;
  logic          rev_s;
  step_t         step;
  logic          fg_raw;
  logic          hs_kill, ls_kill;

  hcd_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({dir_rev, hall_in}),
    .q    (sync_q)
  );

  assign hall_s = sync_q[PHASES-1:0];
  assign rev_s  = sync_q[PHASES];

  hcd_step_lut u_lut (
    .code(hall_s),
    .rev (rev_s),
    .step(step)
  );

  hcd_fg_enc u_fg (
    .code     (hall_s),
    .follow_h1(fg_sel),
    .pull_low (fg_raw)
  );

  // tier 1: everything off; tier 2: low side off
  assign hs_kill = flt_uv | flt_ot | step.bad;
  assign ls_kill = hs_kill | flt_lock | flt_oc | ~pwm_gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_en_n <= '1;
      ls_on   <= '0;
      fg_low  <= 1'b0;
    end else begin
      hs_en_n <= ~(step.hs_on & {PHASES{~hs_kill}});
      ls_on   <= step.ls_sel & {PHASES{~ls_kill}};
      fg_low  <= fg_raw & ~step.bad;
    end
  end
endmodule

// File: rtl/hcd_checker.sv
module hcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_gate,
  input logic       flt_uv,
  input logic       flt_ot,
  input logic       flt_lock,
  input logic       flt_oc,
  input logic [2:0] hs_en_n,
  input logic [2:0] ls_on
);
  a_r11_one_high: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~hs_en_n));

  a_r11_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ls_on));

  a_r11_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
    ((~hs_en_n) & ls_on) == 3'b000);

  a_r5_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_uv || flt_ot) |=> (hs_en_n == 3'b111 && ls_on == 3'b000));

  a_r4_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_lock || flt_oc) |=> (ls_on == 3'b000));

  a_r3_pwm_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_gate |=> (ls_on == 3'b000));
endmodule

bind hall_commutator hcd_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_gate(pwm_gate),
  .flt_uv  (flt_uv),
  .flt_ot  (flt_ot),
  .flt_lock(flt_lock),
  .flt_oc  (flt_oc),
  .hs_en_n (hs_en_n),
  .ls_on   (ls_on)
);

// File: tb/hall_commutator_test.sv
module hall_commutator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_in = 3'b000;
  logic       dir_rev = 1'b0, pwm_gate = 1'b0, flt_uv = 1'b0, flt_ot = 1'b0;
  logic       flt_lock = 1'b0, flt_oc = 1'b0, fg_sel = 1'b0;
  logic [2:0] hs_en_n, ls_on;
  logic       fg_low;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [6:0] q_exp[$];
  string      q_tag[$];

  always #4 clk = ~clk;  // 125 MHz

  hall_commutator uut (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .dir_rev(dir_rev),
    .pwm_gate(pwm_gate), .flt_uv(flt_uv), .flt_ot(flt_ot),
    .flt_lock(flt_lock), .flt_oc(flt_oc), .fg_sel(fg_sel),
    .hs_en_n(hs_en_n), .ls_on(ls_on), .fg_low(fg_low)
  );

  // expected {hs_en_n, ls_on, fg_low} from the requirement tables
  function automatic logic [6:0] model(input logic [2:0] h, input logic rev,
      input logic pwm, input logic uv, input logic ot, input logic lk,
      input logic oc, input logic sel);
    int hi, lo, t;
    logic [2:0] hs, ls;
    logic fg;
    hi = -1; lo = -1;
    case (h)                                   // R1 forward phase indices
      3'b100: begin hi = 2; lo = 0; end
      3'b110: begin hi = 2; lo = 1; end
      3'b010: begin hi = 0; lo = 1; end
      3'b011: begin hi = 0; lo = 2; end
      3'b001: begin hi = 1; lo = 2; end
      3'b101: begin hi = 1; lo = 0; end
      default: ;
    endcase
    if (hi < 0) return {3'b111, 3'b000, 1'b0};  // R6
    if (rev) begin t = hi; hi = lo; lo = t; end  // R2
    hs = 3'b111; ls = 3'b000;
    hs[hi] = 1'b0;
    ls[lo] = 1'b1;
    if (!pwm || lk || oc) ls = 3'b000;           // R3, R4
    if (uv || ot) begin hs = 3'b111; ls = 3'b000; end  // R5
    fg = sel ? !h[2] : (h == 3'b110 || h == 3'b011 || h == 3'b101); // R8 / R7
    return {hs, ls, fg};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [6:0] act,
                       input logic [6:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: apply, settle, push expected
  task automatic apply(input logic [2:0] h, input logic rev, input logic pwm,
      input logic uv, input logic ot, input logic lk, input logic oc,
      input logic sel, input string tag);
    @(negedge clk);
    hall_in = h; dir_rev = rev; pwm_gate = pwm; flt_uv = uv; flt_ot = ot;
    flt_lock = lk; flt_oc = oc; fg_sel = sel;
    repeat (4) @(negedge clk);
    q_exp.push_back(model(h, rev, pwm, uv, ot, lk, oc, sel));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (q_exp.size() > 0) begin
        logic [6:0] e, a;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = {hs_en_n, ls_on, fg_low};
        check(a == e, t, a, e);
        check($onehot0(~hs_en_n) && $onehot0(ls_on) && (((~hs_en_n) & ls_on) == 3'b000),
              {"R11 ", t}, a, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] seq [6];
    seq[0] = 3'b100; seq[1] = 3'b110; seq[2] = 3'b010;
    seq[3] = 3'b011; seq[4] = 3'b001; seq[5] = 3'b101;

    hall_in = 3'b100; pwm_gate = 1'b1;
    repeat (3) @(negedge clk);
    check({hs_en_n, ls_on, fg_low} == 7'b1110000, "R10 reset state",
          {hs_en_n, ls_on, fg_low}, 7'b1110000);
    @(negedge clk); rst_n = 1'b1;

    foreach (seq[i]) apply(seq[i], 1'b0, 1'b1, 0, 0, 0, 0, 1'b0, "R1 R7 forward step");
    foreach (seq[i]) apply(seq[i], 1'b1, 1'b1, 0, 0, 0, 0, 1'b0, "R2 R7 reverse step");
    foreach (seq[i]) apply(seq[i], i[0], 1'b1, 0, 0, 0, 0, 1'b1, "R8 follow H1");
    apply(3'b110, 1'b0, 1'b0, 0, 0, 0, 0, 1'b0, "R3 pwm gate low fwd");
    apply(3'b011, 1'b1, 1'b0, 0, 0, 0, 0, 1'b0, "R3 pwm gate low rev");
    apply(3'b010, 1'b0, 1'b1, 0, 0, 1, 0, 1'b0, "R4 lock fault");
    apply(3'b101, 1'b1, 1'b1, 0, 0, 0, 1, 1'b0, "R4 overcurrent fault");
    apply(3'b001, 1'b0, 1'b1, 1, 0, 0, 0, 1'b0, "R5 undervoltage");
    apply(3'b110, 1'b1, 1'b1, 0, 1, 1, 0, 1'b1, "R5 overtemperature");
    apply(3'b000, 1'b0, 1'b1, 0, 0, 0, 0, 1'b0, "R6 code 000");
    apply(3'b111, 1'b0, 1'b1, 0, 0, 0, 0, 1'b0, "R6 code 111 sel0");
    apply(3'b000, 1'b1, 1'b1, 0, 0, 0, 0, 1'b1, "R6 code 000 sel1");

    // R9 latency: start settled on 100 forward
    apply(3'b100, 1'b0, 1'b1, 0, 0, 0, 0, 1'b0, "R9 settle");
    @(negedge clk); hall_in = 3'b110;
    repeat (2) @(negedge clk);
    check(ls_on == 3'b001, "R9 hall not yet after two edges", {4'b0, ls_on}, 7'b0000001);
    @(negedge clk);
    check(ls_on == 3'b010, "R9 hall after three edges", {4'b0, ls_on}, 7'b0000010);
    pwm_gate = 1'b0;
    @(negedge clk);
    check(ls_on == 3'b000, "R9 pwm after one edge", {4'b0, ls_on}, 7'b0000000);
    pwm_gate = 1'b1; dir_rev = 1'b1;
    repeat (2) @(negedge clk);
    check(hs_en_n == 3'b011, "R9 dir not yet after two edges", {4'b0, hs_en_n}, 7'b0000011);
    @(negedge clk);
    check(hs_en_n == 3'b101, "R9 dir after three edges", {4'b0, hs_en_n}, 7'b0000101);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule